// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Logic

This block is the device end of a three-wire serial memory. A host selects it, shifts commands in one bit per shift-clock rising edge, and gets read data or a ready indication back on a single data-out pin with its own output enable. A command is a start bit, a two-bit operation code and an address. Reads, single-location erase and write, whole-array erase and fill, and the commands that open and close programming all run against an internal register array.

The block is clocked by a fast system clock. Chip select, shift clock and data in pass through a configurable synchronizer, and the shift-clock rising edge is found by comparing successive samples. A static organization input picks 16-bit words with a 10-bit address, or bytes with an 11-bit address. The array depth is a parameter. Each programming operation starts a busy period of a set number of system-clock cycles, and the host can poll that period by dropping and raising chip select.

Top module: `eep3w_slave`

## Requirements
- R1: Data-in bits at 0 in front of the first 1 are skipped. A command starts with a 1 (start bit), then two operation-code bits, MSB first: 10 read, 01 write, 11 erase, 00 extended.
- R2: With `org_i` high a word is 16 bits and the address is 10 bits. With it low a word is 8 bits and the address is 11 bits. Byte address 2k is the low byte and 2k+1 the high byte of word k. Addresses wrap at the array size.
- R3: A read drives a single 0 on data out after the last address bit's rising edge. Each following shift-clock rising edge then puts out one data bit, MSB first.
- R4: While chip select stays high, a read goes on to the next address and streams that word straight after the previous one, with no extra 0. The last location is followed by location 0.
- R5: After reset programming is locked. Erase, write, erase-all and write-all commands sent while locked leave the array unchanged and start no busy period. Reads work whether or not programming is locked.
- R6: For operation code 00, the two most significant address bits select the command: 11 unlocks programming, 00 locks it, 10 erases all locations, 01 writes all locations. All other address bits are ignored.
- R7: Write stores the shifted-in word at the address, with no erase needed first. Erase sets every bit of the addressed word to 1.
- R8: Erase-all sets every bit of the array to 1. Write-all stores the data word in every location.
- R9: A programming operation stays busy for `PROG_CYCLES` system clocks after its last bit. Any command sent while busy is ignored.
- R10: If chip select goes low and then high again while busy, data out is enabled and reads 0 while busy and 1 once ready. If chip select is raised only after the busy period has ended, data out stays disabled.
- R11: The data-out enable is low whenever chip select has been low for one synchronized cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out / ready flag |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Burst reads cross word boundaries and the top of the array. A design that re-sent the dummy 0 between words, or failed to wrap, would shift every later bit out of place. Byte-mode writes are read back as 16-bit words, which catches a wrong byte-lane order. Programming commands are sent while locked and while busy. A design that acted on either would change locations the bench later reads as unchanged. The ready flag is polled both during and after the busy period. The bench measures the busy length, so a status that came up early, or that appeared when chip select rose only after the period had ended, is reported.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
   } eep_state_e;

   typedef enum logic [1:0] {
      OP_EXT = 2'b00, OP_WRITE = 2'b01, OP_READ = 2'b10, OP_ERASE = 2'b11
   } eep_op_e;

   typedef enum logic [1:0] {
      EX_LOCK = 2'b00, EX_FILL = 2'b01, EX_WIPE = 2'b10, EX_UNLOCK = 2'b11
   } eep_ext_e;
endpackage

// File: rtl/eep3w_pin_sync.sv
module eep3w_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic cs_s,
   output logic di_s,
   output logic sk_rise,
   output logic cs_rise
);
   logic [2:0] pins_s;
   logic       sk_q, cs_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign pins_s = {cs, sk, di};
      end else begin : g_chain
         logic [2:0] stg [STAGES];
         for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[g] <= '0;
                  else        stg[g] <= {cs, sk, di};
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[g] <= '0;
                  else        stg[g] <= stg[g-1];
            end
         end
         assign pins_s = stg[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sk_q <= 1'b0;
         cs_q <= 1'b0;
      end else begin
         sk_q <= pins_s[1];
         cs_q <= pins_s[2];
      end

   assign cs_s    = pins_s[2];
   assign di_s    = pins_s[0];
   assign sk_rise = pins_s[1] & ~sk_q;
   assign cs_rise = pins_s[2] & ~cs_q;
endmodule

// File: rtl/eep3w_prog_timer.sv
module eep3w_prog_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;

   assign busy = (cnt != '0);

   // a new programming strobe never lands inside a running cycle
   assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
   parameter int NBYTES = 32,
   localparam int BIDX = $clog2(NBYTES),
   localparam int WIDX = BIDX - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            org,
   input  logic [BIDX-1:0] rd_idx,
   output logic [15:0]     rd_word,
   input  logic            wr_one,
   input  logic            wr_all,
   input  logic [BIDX-1:0] wr_idx,
   input  logic [15:0]     wr_data
);
   logic [7:0] mem [NBYTES];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int b = 0; b < NBYTES; b++) mem[b] <= 8'hFF;
      end else if (wr_all) begin
         for (int b = 0; b < NBYTES; b++)
            mem[b] <= (b % 2 == 1) ? wr_data[15:8] : wr_data[7:0];
      end else if (wr_one) begin
         if (org) begin
            mem[{wr_idx[WIDX-1:0], 1'b1}] <= wr_data[15:8];
            mem[{wr_idx[WIDX-1:0], 1'b0}] <= wr_data[7:0];
         end else begin
            mem[wr_idx] <= wr_data[7:0];
         end
      end

   assign rd_word = org ? {mem[{rd_idx[WIDX-1:0], 1'b1}], mem[{rd_idx[WIDX-1:0], 1'b0}]}
                        : {mem[rd_idx], 8'h00};
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
   import eep3w_pkg::*;
#(
   parameter int ADDR16_BITS = 10,
   parameter int NBYTES      = 32,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org_i,
   output logic do_o,
   output logic do_oe_o
);
   localparam int A8   = ADDR16_BITS + 1;
   localparam int BIDX = $clog2(NBYTES);
   localparam int WIDX = BIDX - 1;
   localparam int MAXL = (A8 > 16) ? A8 : 16;
   localparam int CW   = $clog2(MAXL + 1);

   generate
      if (NBYTES < 4 || (1 << BIDX) != NBYTES) begin : g_bad_depth
         $error("NBYTES must be a power of two, at least 4");
      end
      if (ADDR16_BITS < WIDX || ADDR16_BITS < 2) begin : g_bad_addr
         $error("ADDR16_BITS too small for the array");
      end
   endgenerate

   logic cs_s, di_s, sk_rise, cs_rise, busy;
   eep_state_e st;
   logic [1:0]      op_q;
   logic [CW-1:0]   bcnt, aw, wlen;
   logic [A8-1:0]   addr_sr, a_full;
   logic [15:0]     data_sr, d_full, rd_sh, rd_word, wr_data;
   logic [BIDX-1:0] ptr, ptr_inc, idx_dec, rd_idx, wr_idx;
   logic [1:0]      ext;
   logic wen_q, stat_on, out_bit;
   logic addr_end, data_end, wr_one, wr_all, prog_go;

   eep3w_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs(cs_i), .sk(sk_i), .di(di_i),
      .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_rise(cs_rise));

   eep3w_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy));

   eep3w_array #(.NBYTES(NBYTES)) u_array (
      .clk(clk), .rst_n(rst_n), .org(org_i), .rd_idx(rd_idx), .rd_word(rd_word),
      .wr_one(wr_one), .wr_all(wr_all), .wr_idx(wr_idx), .wr_data(wr_data));

   // field extraction from the bit arriving on this edge
   assign aw      = org_i ? CW'(ADDR16_BITS) : CW'(A8);
   assign wlen    = org_i ? CW'(16) : CW'(8);
   assign a_full  = {addr_sr[A8-2:0], di_s};
   assign d_full  = {data_sr[14:0], di_s};
   assign ext     = org_i ? a_full[ADDR16_BITS-1 -: 2] : a_full[A8-1 -: 2];
   assign idx_dec = org_i ? {1'b0, a_full[WIDX-1:0]} : a_full[BIDX-1:0];
   assign ptr_inc = org_i ? {1'b0, ptr[WIDX-1:0] + 1'b1} : ptr + 1'b1;
   assign rd_idx  = (st == ST_ADDR) ? idx_dec : ptr_inc;

   // programming strobes
   assign addr_end = cs_s && sk_rise && (st == ST_ADDR) && (bcnt == aw - 1'b1);
   assign data_end = cs_s && sk_rise && (st == ST_DATA) && (bcnt == wlen - 1'b1);
   assign wr_one   = wen_q && ((addr_end && op_q == OP_ERASE) ||
                               (data_end && op_q == OP_WRITE));
   assign wr_all   = wen_q && ((addr_end && op_q == OP_EXT && ext == EX_WIPE) ||
                               (data_end && op_q == OP_EXT));
   assign wr_idx   = addr_end ? idx_dec : ptr;
   assign wr_data  = !data_end ? 16'hFFFF
                   : (org_i ? d_full : {d_full[7:0], d_full[7:0]});
   assign prog_go  = wr_one | wr_all;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st <= ST_IDLE; op_q <= '0; bcnt <= '0; addr_sr <= '0; data_sr <= '0;
         rd_sh <= '0; ptr <= '0; wen_q <= 1'b0; stat_on <= 1'b0; out_bit <= 1'b0;
      end else if (!cs_s) begin
         st      <= ST_IDLE;
         stat_on <= 1'b0;
      end else begin
         if (cs_rise && busy) stat_on <= 1'b1;
         if (sk_rise) begin
            case (st)
               ST_IDLE: if (di_s && !busy) begin
                  st <= ST_OPC; bcnt <= '0; stat_on <= 1'b0;
               end
               ST_OPC: begin
                  op_q <= {op_q[0], di_s};
                  if (bcnt == CW'(1)) begin st <= ST_ADDR; bcnt <= '0; end
                  else bcnt <= bcnt + 1'b1;
               end
               ST_ADDR: begin
                  addr_sr <= a_full;
                  if (addr_end) begin
                     bcnt <= '0;
                     ptr  <= idx_dec;
                     st   <= ST_DONE;
                     case (op_q)
                        OP_READ:  begin st <= ST_READ; rd_sh <= rd_word; out_bit <= 1'b0; end
                        OP_WRITE: st <= ST_DATA;
                        OP_ERASE: st <= ST_DONE;
                        default: case (ext)
                           EX_UNLOCK: wen_q <= 1'b1;
                           EX_LOCK:   wen_q <= 1'b0;
                           EX_FILL:   st <= ST_DATA;
                           default:   st <= ST_DONE;
                        endcase
                     endcase
                  end else bcnt <= bcnt + 1'b1;
               end
               ST_DATA: begin
                  data_sr <= d_full;
                  if (data_end) st <= ST_DONE;
                  else bcnt <= bcnt + 1'b1;
               end
               ST_READ: begin
                  out_bit <= rd_sh[15];
                  if (bcnt == wlen - 1'b1) begin
                     bcnt <= '0; ptr <= ptr_inc; rd_sh <= rd_word;
                  end else begin
                     rd_sh <= {rd_sh[14:0], 1'b0}; bcnt <= bcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end

   assign do_o    = stat_on ? ~busy : out_bit;
   assign do_oe_o = cs_s && (stat_on || st == ST_READ);

   assert_oe_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !do_oe_o);
   assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_READ) |-> (do_o == 1'b0));
   assert_status_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_on) |-> busy);
   assert_locked_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen_q));
endmodule

// File: tb/tb_eep3w_slave.sv
module tb_eep3w_slave;
   localparam int PROG = 1000;
   localparam int H    = 6;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
   logic do_w, oe_w;
   int checks = 0, fails = 0;
   bit finished = 1'b0;

   logic [7:0] bm [32];
   bit wen_m = 1'b0;

   logic [1:0] expv_q [$];
   string      tag_q  [$];
   logic s_oe, s_do;
   event smp_ev;

   always #4 clk = ~clk;

   eep3w_slave dut (.clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
                    .org_i(org), .do_o(do_w), .do_oe_o(oe_w));

   // monitor: pop expected bit and compare to the sampled output
   always @(smp_ev) begin
      logic [1:0] e;
      string t;
      e = expv_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({s_oe, s_do} !== e) begin
         fails++;
         $display("FAIL %s act oe/do=%b exp=%b", t, {s_oe, s_do}, e);
      end
   end

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", t, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sk_bit(input logic b, input bit smp);
      di = b; waitc(2); sk = 1'b1; waitc(H);
      if (smp) begin s_oe = oe_w; s_do = do_w; ->smp_ev; waitc(1); end
      sk = 1'b0; waitc(H);
   endtask

   task automatic cs_up();   cs = 1'b1; waitc(6); endtask
   task automatic cs_down(); cs = 1'b0; di = 1'b0; waitc(6); endtask

   function automatic int awid(input logic o); return o ? 10 : 11; endfunction
   function automatic logic [15:0] wd16(input int w);
      return {bm[(2 * w + 1) % 32], bm[(2 * w) % 32]};
   endfunction

   task automatic send(input int v, input int n);
      for (int i = n - 1; i >= 0; i--) sk_bit(logic'((v >> i) & 1), 1'b0);
   endtask

   // full programming frame; nd = number of data bits (0 if none)
   task automatic cmd(input int op, input int a, input int d, input int nd);
      cs_up(); sk_bit(1'b1, 1'b0); send(op, 2); send(a, awid(org));
      if (nd > 0) send(d, nd);
      cs_down();
   endtask

   task automatic ext_cmd(input int code);
      cmd(0, code << (awid(org) - 2), 0, 0);
   endtask

   task automatic read_chk(input int a, input int nw, input int pre0, input string t);
      int aw;
      aw = awid(org);
      cs_up();
      for (int i = 0; i < pre0; i++) sk_bit(1'b0, 1'b0);
      sk_bit(1'b1, 1'b0); send(2, 2); send(a >> 1, aw - 1);
      expv_q.push_back(2'b10); tag_q.push_back({t, " dummy R3"});
      sk_bit(logic'(a & 1), 1'b1);
      for (int k = 0; k < nw; k++) begin
         logic [15:0] w;
         int wl;
         wl = org ? 16 : 8;
         w  = org ? wd16((a + k) % 16) : {8'h00, bm[(a + k) % 32]};
         for (int j = wl - 1; j >= 0; j--) begin
            expv_q.push_back({1'b1, w[j]}); tag_q.push_back(t);
            sk_bit(1'b0, 1'b1);
         end
      end
      cs_down();
   endtask

   task automatic wait_ready(input int min_cyc, input string t);
      int n;
      cs_up();
      chk(oe_w === 1'b1 && do_w === 1'b0, {t, " busy shown R10"}, {oe_w, do_w}, 2);
      n = 6;
      while (do_w !== 1'b1 && n < PROG + 200) begin waitc(1); n++; end
      chk(oe_w === 1'b1 && do_w === 1'b1, {t, " ready shown R10"}, {oe_w, do_w}, 3);
      chk(n >= min_cyc, {t, " busy length R9"}, n, min_cyc);
      cs_down();
   endtask

   task automatic m_wr16(input int w, input logic [15:0] d);
      if (wen_m) begin bm[(2 * w) % 32] = d[7:0]; bm[(2 * w + 1) % 32] = d[15:8]; end
   endtask

   task automatic m_all(input logic [15:0] d);
      if (wen_m) for (int b = 0; b < 32; b++) bm[b] = (b % 2 == 1) ? d[15:8] : d[7:0];
   endtask

   initial begin
      for (int b = 0; b < 32; b++) bm[b] = 8'hFF;
      waitc(5); rst_n = 1'b1; waitc(4);

      chk(oe_w === 1'b0, "reset oe R11", oe_w, 0);
      read_chk(3, 1, 0, "reset read R3");

      // locked: write ignored
      cmd(1, 2, 16'hA5C3, 16); m_wr16(2, 16'hA5C3);
      cs_up(); chk(oe_w === 1'b0, "no busy when locked R5", oe_w, 0); cs_down();
      read_chk(2, 1, 0, "locked write R5");

      ext_cmd(3); wen_m = 1'b1;
      cmd(1, 2, 16'h1234, 16); m_wr16(2, 16'h1234);
      wait_ready(PROG - 100, "write");
      cmd(1, 0, 16'h00F0, 16); m_wr16(0, 16'h00F0); wait_ready(0, "w0");
      cmd(1, 15, 16'hABCD, 16); m_wr16(15, 16'hABCD); wait_ready(0, "w15");
      read_chk(2, 1, 0, "write readback R7");
      read_chk(14, 4, 0, "burst wrap R4");

      org = 1'b0;
      read_chk(4, 2, 0, "byte burst R2");
      cmd(1, 7, 8'h5A, 8); if (wen_m) bm[7] = 8'h5A;
      wait_ready(0, "byte write R2");
      org = 1'b1;
      read_chk(3, 1, 0, "byte lane R2");

      cmd(3, 2, 0, 0); m_wr16(2, 16'hFFFF); wait_ready(0, "erase");
      read_chk(2, 1, 0, "erase R7");

      // command during busy ignored
      cmd(1, 5, 16'h0F0F, 16); m_wr16(5, 16'h0F0F);
      cmd(1, 6, 16'h1111, 16);
      wait_ready(0, "busy cmd R9");
      read_chk(5, 2, 0, "busy ignored R9");

      // status not driven after the cycle ended
      cmd(1, 7, 16'h7777, 16); m_wr16(7, 16'h7777);
      waitc(PROG + 200);
      cs_up(); chk(oe_w === 1'b0, "late cs no status R10", oe_w, 0); cs_down();

      ext_cmd(0); wen_m = 1'b0;
      cmd(1, 8, 16'h8888, 16); m_wr16(8, 16'h8888);
      read_chk(7, 2, 0, "lock then read R6");

      ext_cmd(3); wen_m = 1'b1;
      cmd(0, 1 << 8, 16'hBEEF, 16); m_all(16'hBEEF);
      wait_ready(0, "fill R8");
      read_chk(9, 2, 0, "fill R8");
      read_chk(0, 1, 3, "leading zeros R1");
      ext_cmd(2); m_all(16'hFFFF); wait_ready(0, "wipe R8");
      read_chk(2, 1, 0, "wipe R8");

      // abort a read mid-stream
      cs_up(); sk_bit(1'b1, 1'b0); send(2, 2); send(4, 10); send(0, 3);
      cs_down();
      chk(oe_w === 1'b0, "cs low mid read R11", oe_w, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule